// File: doc/BRIEF.md
# Non-Destructive RAM Size Prober

This block is a bus master that learns whether a memory window holds working RAM and, if it does, how large that RAM is. It is started once with a base byte address and an upper size bound. It then runs a fixed sequence of word accesses on a simple request/acknowledge bus and reports the size in bytes, where zero means nothing was found. A single-cycle completion strobe marks the end of the run.

Only the words at byte offsets 0 and 4 of the window are ever written, and both are restored to their earlier contents before the run finishes. Anything stored above offset 8, such as battery-backed data, is never written. First a two-phase presence test runs. It alternates complementary patterns and drives a different value onto the data bus between each write and its read-back, so that a floating bus that keeps the last value driven cannot pass for memory. The size is then found by stepping a power-of-two offset upward. At each step the complement of the word at that offset is written to offset 0, and the block watches for the two locations to alias. If the run at the full bus width finds nothing, the block raises a half-width select for the memory controller and repeats the whole run once.

Top module: `prb_ram_sizer`

## Requirements
- R1: During a run, writes go only to byte offsets 0 and 4 of the window. When the run ends, both words hold the values they had before it began, and no other word has changed.
- R2: The run begins with a read of offset 0 and a read of offset 4. The presence test then proceeds in this order: write 0x5555AAAA to offset 0, write 0xAAAA5555 to offset 4, read offset 0. It continues with: write 0xAAAA5555 to offset 0, write 0x5555AAAA to offset 4, read offset 0.
- R3: If either presence read-back differs from the pattern written to offset 0 just before it, the result of that pass is size 0 and no sizing is done.
- R4: Sizing starts with offset 4 and doubles the offset after each step. At each step the word at the offset is read, its complement is written to offset 0, and then offset 0 and the offset are read again. If the two reads are equal, the reported size is that offset.
- R5: If the offset reaches the maximum size without aliasing being detected, the reported size is the maximum size. The reported size never exceeds the maximum.
- R6: half_width is 0 for the first pass. If that pass yields 0, half_width goes to 1, a second full pass runs, and its result is reported. Otherwise half_width stays 0.
- R7: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until the cycle in which mem_ack is high. mem_req drops in the following cycle.
- R8: done is high for exactly one cycle, in the cycle right after the cycle in which the final restore write (offset 4) is acknowledged. No request is outstanding while done is high. size holds its value until the next run ends.
- R9: After reset, mem_req, done, size and half_width are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe run (taken while idle) |
| base_addr | input | ADDR_W | Byte address of window offset 0, word aligned |
| max_size | input | ADDR_W+1 | Upper size bound in bytes, power of two, at most 2^ADDR_W |
| half_width | output | 1 | Bus width select for the memory controller: 0 full, 1 half |
| mem_req | output | 1 | Access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid while mem_ack is high |
| mem_ack | input | 1 | Access acknowledge, one cycle |
| size | output | ADDR_W+1 | Detected size in bytes, 0 when no RAM was found |
| done | output | 1 | One-cycle completion strobe |

## Verification
Detecting aliasing and running out of sizing steps can both happen on the same final step. The bench provokes this with a memory of half the maximum, where the wrap shows up at the last offset below the bound, and also with a memory exactly at the bound, where no wrap can appear. It expects half the maximum in the first case and the maximum in the second. A second overlap is the final restore acknowledge landing on the cycle that decides between a half-width retry and completion. The bench judges this by checking the cycle in which done appears against the cycle of the last write acknowledge, and by checking half_width, in runs that hit and miss at full width.

// File: rtl/prb_pkg.sv
package prb_pkg;

  // One state per bus access, plus idle and the sizing loop test.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE0,
    ST_SAVE4,
    ST_PA_0,
    ST_PB_4,
    ST_CHK_A,
    ST_PB_0,
    ST_PA_4,
    ST_CHK_B,
    ST_STEP,
    ST_RD_T,
    ST_WR_C,
    ST_RD_0,
    ST_RD_T2,
    ST_RST0,
    ST_RST4
  } prb_state_e;

endpackage

// File: rtl/prb_bus_port.sv
module prb_bus_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fin
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (go) begin
      mem_req   <= 1'b1;
      mem_we    <= go_we;
      mem_addr  <= go_addr;
      mem_wdata <= go_wdata;
    end else if (mem_req && mem_ack) begin
      mem_req   <= 1'b0;
    end
  end

  assign fin = mem_req & mem_ack;

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

endmodule

// File: rtl/prb_offset_step.sv
module prb_offset_step #(
  parameter int SIZE_W = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [SIZE_W-1:0] limit,
  output logic [SIZE_W-1:0] ofs,
  output logic              more
);

  localparam logic [SIZE_W-1:0] FIRST_OFS = SIZE_W'(4);

  always_ff @(posedge clk) begin
    if (rst || load) ofs <= FIRST_OFS;
    else if (adv)    ofs <= ofs << 1;
  end

  assign more = (ofs < limit);

endmodule

// File: rtl/prb_ram_sizer.sv
module prb_ram_sizer
  import prb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W:0]   max_size,
  output logic              half_width,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [ADDR_W:0]   size,
  output logic              done
);

  localparam int SIZE_W = ADDR_W + 1;
  localparam logic [DATA_W-1:0] PAT_A = {{(DATA_W/4){2'b01}}, {(DATA_W/4){2'b10}}};
  localparam logic [DATA_W-1:0] PAT_B = ~PAT_A;
  localparam logic [SIZE_W-1:0] OFS4  = SIZE_W'(4);

  prb_state_e        st;
  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] max_q, res_q, ofs;
  logic [DATA_W-1:0] save0, save4, tword, r0word;
  logic              fail_q, launched, fin, more;
  logic              is_acc, acc_we, go;
  logic [SIZE_W-1:0] acc_off;
  logic [DATA_W-1:0] acc_wd;
  logic              step_load, step_adv;

  // Access descriptor for the current state
  always_comb begin
    is_acc  = 1'b1;
    acc_we  = 1'b0;
    acc_off = '0;
    acc_wd  = PAT_A;
    unique case (st)
      ST_SAVE0: ;
      ST_SAVE4: acc_off = OFS4;
      ST_PA_0:  acc_we  = 1'b1;
      ST_PB_4:  begin acc_we = 1'b1; acc_off = OFS4; acc_wd = PAT_B; end
      ST_CHK_A: ;
      ST_PB_0:  begin acc_we = 1'b1; acc_wd = PAT_B; end
      ST_PA_4:  begin acc_we = 1'b1; acc_off = OFS4; end
      ST_CHK_B: ;
      ST_RD_T:  acc_off = ofs;
      ST_WR_C:  begin acc_we = 1'b1; acc_wd = ~tword; end
      ST_RD_0:  ;
      ST_RD_T2: acc_off = ofs;
      ST_RST0:  begin acc_we = 1'b1; acc_wd = save0; end
      ST_RST4:  begin acc_we = 1'b1; acc_off = OFS4; acc_wd = save4; end
      default:  is_acc = 1'b0;
    endcase
  end

  assign go        = is_acc && !launched;
  assign step_load = (st == ST_CHK_B) && fin && !fail_q && (mem_rdata == PAT_B);
  assign step_adv  = (st == ST_RD_T2) && fin && (r0word != mem_rdata);

  prb_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_we    (acc_we),
    .go_addr  (ADDR_W'({1'b0, base_q} + acc_off)),
    .go_wdata (acc_wd),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .fin      (fin)
  );

  prb_offset_step #(.SIZE_W(SIZE_W)) u_step (
    .clk  (clk),
    .rst  (rst),
    .load (step_load),
    .adv  (step_adv),
    .limit(max_q),
    .ofs  (ofs),
    .more (more)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      base_q     <= '0;
      max_q      <= '0;
      res_q      <= '0;
      save0      <= '0;
      save4      <= '0;
      tword      <= '0;
      r0word     <= '0;
      fail_q     <= 1'b0;
      launched   <= 1'b0;
      half_width <= 1'b0;
      size       <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) launched <= 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          base_q     <= base_addr;
          max_q      <= max_size;
          half_width <= 1'b0;
          st         <= ST_SAVE0;
        end
        ST_STEP: begin
          if (more) st <= ST_RD_T;
          else begin
            res_q <= max_q;
            st    <= ST_RST0;
          end
        end
        default: if (fin) begin
          launched <= 1'b0;
          case (st)
            ST_SAVE0: begin save0 <= mem_rdata; st <= ST_SAVE4; end
            ST_SAVE4: begin save4 <= mem_rdata; st <= ST_PA_0; end
            ST_PA_0:  st <= ST_PB_4;
            ST_PB_4:  st <= ST_CHK_A;
            ST_CHK_A: begin fail_q <= (mem_rdata != PAT_A); st <= ST_PB_0; end
            ST_PB_0:  st <= ST_PA_4;
            ST_PA_4:  st <= ST_CHK_B;
            ST_CHK_B: begin
              if (fail_q || mem_rdata != PAT_B) begin
                res_q <= '0;
                st    <= ST_RST0;
              end else st <= ST_STEP;
            end
            ST_RD_T:  begin tword <= mem_rdata; st <= ST_WR_C; end
            ST_WR_C:  st <= ST_RD_0;
            ST_RD_0:  begin r0word <= mem_rdata; st <= ST_RD_T2; end
            ST_RD_T2: begin
              if (r0word == mem_rdata) begin
                res_q <= ofs;
                st    <= ST_RST0;
              end else st <= ST_STEP;
            end
            ST_RST0:  st <= ST_RST4;
            ST_RST4:  begin
              if (res_q == '0 && !half_width) begin
                half_width <= 1'b1;
                st         <= ST_SAVE0;
              end else begin
                size <= res_q;
                done <= 1'b1;
                st   <= ST_IDLE;
              end
            end
            default:  st <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  // R1
  write_window_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr == base_q || mem_addr == ADDR_W'(base_q + ADDR_W'(4))));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  // R5
  size_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (size <= max_q));

endmodule

// File: tb/sim_prb_ram_sizer.sv
module sim_prb_ram_sizer;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MW = 1024;
  localparam logic [DW-1:0] PA = 32'h5555AAAA;
  localparam logic [DW-1:0] PB = 32'hAAAA5555;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0]   max_size = '0;
  logic          half_width, mem_req, mem_we, mem_ack, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [AW:0]   size;

  always #5 clk = ~clk;

  prb_ram_sizer #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .max_size(max_size),
    .half_width(half_width), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .size(size), .done(done)
  );

  // Memory model: kind 0 absent, 1 full width, 2 half width, 3 word 0 stuck at PA
  int            kind, msize_w, lat, cnt, bad_wr, nacc, idx;
  logic [AW-1:0] cur_base, offv;
  logic [DW-1:0] mem [0:MW-1];
  logic [DW-1:0] bus_last, rd;
  logic          pres;
  logic          lwe [0:7];
  logic [AW-1:0] loff [0:7];
  logic [DW-1:0] ldat [0:7];
  int            ncyc, last_wack, done_cyc, done_cnt;
  int            n_chk, n_fail;

  initial begin
    mem_ack = 1'b0; mem_rdata = '0; cnt = 0; kind = 0; msize_w = 1; lat = 0;
    bus_last = '0; cur_base = '0; bad_wr = 0; nacc = 0;
  end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        cnt  = 0;
        offv = mem_addr - cur_base;
        idx  = int'(offv >> 2) & (msize_w - 1);
        pres = (kind == 1 && !half_width) || (kind == 2 && half_width) || (kind == 3);
        if (nacc < 8) begin lwe[nacc] = mem_we; loff[nacc] = offv; ldat[nacc] = mem_wdata; end
        nacc++;
        if (mem_we) begin
          if (offv != 0 && offv != 4) bad_wr++;
          if (pres) mem[idx] = mem_wdata;
          bus_last = mem_wdata;
        end else begin
          rd = !pres ? bus_last : ((kind == 3 && idx == 0) ? PA : mem[idx]);
          mem_rdata <= rd;
          bus_last = rd;
        end
        mem_ack <= 1'b1;
      end else cnt++;
    end
  end

  always @(negedge clk) begin
    ncyc++;
    if (mem_ack && mem_we) last_wack = ncyc;
    if (done) begin done_cyc = ncyc; done_cnt++; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prep(input int k, input int words, input int l, input logic [AW-1:0] b);
    kind = k; msize_w = words; lat = l; cur_base = b; cnt = 0;
    bad_wr = 0; nacc = 0; done_cnt = 0; done_cyc = -1; last_wack = -2;
    for (int i = 0; i < MW; i++) mem[i] = {16'hC0DE, 16'(i)};
  endtask

  task automatic run_probe(input logic [AW-1:0] b, input logic [AW:0] mx);
    int w = 0;
    @(negedge clk);
    base_addr = b; max_size = mx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == 0 && w < 20000) begin @(negedge clk); w++; end
    if (done_cnt == 0) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 actual=no done expected=done");
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic post(input string tag, input logic [AW:0] exp_size, input logic exp_half);
    chk({tag, " R4 R5 size"}, 64'(size), 64'(exp_size));
    chk({tag, " R6 half_width"}, 64'(half_width), 64'(exp_half));
    chk({tag, " R1 stray writes"}, 64'(bad_wr), 64'd0);
    if (kind != 3) chk({tag, " R1 word0 restored"}, 64'(mem[0]), 64'({16'hC0DE, 16'd0}));
    if (msize_w > 1) chk({tag, " R1 word4 restored"}, 64'(mem[1]), 64'({16'hC0DE, 16'd1}));
    if (msize_w > 5) chk({tag, " R1 upper word kept"}, 64'(mem[5]), 64'({16'hC0DE, 16'd5}));
    chk({tag, " R8 done one cycle"}, 64'(done_cnt), 64'd1);
    chk({tag, " R8 done timing"}, 64'(done_cyc), 64'(last_wack + 1));
  endtask

  task automatic t_reset;
    chk("R9 reset req", 64'(mem_req), 64'd0);
    chk("R9 reset done", 64'(done), 64'd0);
    chk("R9 reset size", 64'(size), 64'd0);
    chk("R9 reset half_width", 64'(half_width), 64'd0);
  endtask

  task automatic t_absent;
    prep(0, 16, 1, 16'h0000);
    run_probe(16'h0000, 17'd1024);
    post("absent R3", '0, 1'b1);
  endtask

  task automatic t_wide_order;
    prep(1, 16, 0, 16'h0000);
    run_probe(16'h0000, 17'd1024);
    post("wide64", 17'd64, 1'b0);
    chk("R2 acc0 read", 64'({lwe[0], loff[0]}), 64'({1'b0, 16'd0}));
    chk("R2 acc1 read", 64'({lwe[1], loff[1]}), 64'({1'b0, 16'd4}));
    chk("R2 acc2", 64'({lwe[2], loff[2], ldat[2]}), 64'({1'b1, 16'd0, PA}));
    chk("R2 acc3", 64'({lwe[3], loff[3], ldat[3]}), 64'({1'b1, 16'd4, PB}));
    chk("R2 acc4 read", 64'({lwe[4], loff[4]}), 64'({1'b0, 16'd0}));
    chk("R2 acc5", 64'({lwe[5], loff[5], ldat[5]}), 64'({1'b1, 16'd0, PB}));
    chk("R2 acc6", 64'({lwe[6], loff[6], ldat[6]}), 64'({1'b1, 16'd4, PA}));
    chk("R2 acc7 read", 64'({lwe[7], loff[7]}), 64'({1'b0, 16'd0}));
  endtask

  task automatic t_narrow;
    prep(2, 64, 2, 16'h0000);
    run_probe(16'h0000, 17'd1024);
    post("narrow256 R6", 17'd256, 1'b1);
  endtask

  task automatic t_bigger_than_max;
    prep(1, 1024, 1, 16'h0000);
    run_probe(16'h0000, 17'd512);
    post("big R5", 17'd512, 1'b0);
  endtask

  task automatic t_last_step;
    prep(1, 128, 0, 16'h0000);
    run_probe(16'h0000, 17'd1024);
    post("half-of-max R4", 17'd512, 1'b0);
    prep(1, 256, 0, 16'h0000);
    run_probe(16'h0000, 17'd1024);
    post("equal-max R5", 17'd1024, 1'b0);
  endtask

  task automatic t_stuck;
    prep(3, 64, 1, 16'h0000);
    run_probe(16'h0000, 17'd1024);
    post("stuck R3", '0, 1'b1);
  endtask

  task automatic t_offset_base;
    prep(1, 32, 3, 16'h1000);
    run_probe(16'h1000, 17'h800);
    post("base R4", 17'd128, 1'b0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; ncyc = 0; done_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_absent();
    t_wide_order();
    t_narrow();
    t_bigger_than_max();
    t_last_step();
    t_stuck();
    t_offset_base();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule